// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one large first-in first-out buffer from several identical storage slices connected in a ring. The slices share the write data, write request and read request lines. None of them sees a global address. Instead, two tokens circulate around the ring: a write token and a read token. Only the slice holding the write token stores incoming words. Only the slice holding the read token returns words.

When a slice stores a word into its highest location, it passes the write token to its successor. It does this with a one-cycle pulse on its write hand-off output, which is wired to the next slice's write hand-off input. Reads move the read token the same way, over a separate hand-off line. An active-low first-load vector picks the slice that owns both tokens after reset. The top level ORs the slice outputs to form the system flags and the read-data bus.

Use it as a synchronous buffer of `SLICES * SLICE_DEPTH` words, with a one-cycle read latency.

Top module: `token_ring_fifo`

## Requirements
- R1: While reset is high, and on the first cycle after it, `empty_o` is 1, `full_o` is 0 and `rd_valid_o` is 0.
- R2: A write is accepted only while `full_o` is 0. `full_o` rises after exactly `SLICES*SLICE_DEPTH` net stored words. Writes presented while full are dropped and never appear at the read side.
- R3: A read request while `empty_o` is 1 has no effect. `rd_valid_o` stays 0 on the following cycle and the stored contents are unchanged.
- R4: Words leave in exactly the order they were accepted, across every slice boundary and ring wrap-around.
- R5: An accepted read drives `rd_valid_o` high with the word on `rd_data_o` in the cycle after the request edge. At most one slice enables its read data at a time.
- R6: Exactly one slice owns each token at all times. Bit i of `wr_owner_o` (resp. `rd_owner_o`) marks slice i. The write owner index equals (first slice + accepted writes / `SLICE_DEPTH`) mod `SLICES`. The read owner index follows the same rule with accepted reads.
- R7: After reset, the slice i whose `first_load_n[i]` is 0 owns both tokens. The others own neither.
- R8: A write and a read presented in the same cycle are both accepted when the buffer is neither full nor empty.
- R9: `empty_o` is 1 exactly when no word is stored. `full_o` falls on the cycle after one read of a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_load_n | input | SLICES | Active-low first-slice select, one bit low |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| rd_req | input | 1 | Read request |
| rd_data_o | output | WIDTH | Read word, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read word present this cycle |
| full_o | output | 1 | System full flag |
| empty_o | output | 1 | System empty flag |
| wr_owner_o | output | SLICES | One-hot write token position |
| rd_owner_o | output | SLICES | One-hot read token position |

## Verification
The hardest case to reach is a full buffer whose read and write tokens sit in the same slice, one lap apart. In that state the write slot is occupied by data that has not yet been read. The stimulus gets there by resetting with each slice as the first one. It fills past capacity, drains part of the buffer, and then runs mixed, overlapping read and write patterns long enough for both tokens to wrap the ring several times. A reference queue and arithmetic token positions are checked every cycle.

// File: rtl/trf_pkg.sv
package trf_pkg;
  function automatic int addr_bits(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/trf_token_ptr.sv
module trf_token_ptr #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          first_n,
  input  logic          step,
  input  logic          hand_in,
  output logic [AW-1:0] ptr_q,
  output logic          own_q,
  output logic          hand_out
);
  logic last;
  assign last     = (ptr_q == AW'(DEPTH - 1));
  assign hand_out = step & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      own_q <= ~first_n;
    end else begin
      own_q <= (own_q & ~hand_out) | hand_in;
      if (step) ptr_q <= last ? '0 : ptr_q + 1'b1;
    end
  end

  assert_step_needs_token_R6: assert property (@(posedge clk) disable iff (rst)
    step |-> own_q);
  assert_no_double_token_R6: assert property (@(posedge clk) disable iff (rst)
    (own_q && !hand_out) |-> !hand_in);
endmodule

// File: rtl/trf_store.sv
module trf_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/trf_slice.sv
module trf_slice
  import trf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             wr_hand_in,
  input  logic             rd_hand_in,
  output logic             wr_hand_out,
  output logic             rd_hand_out,
  output logic             wr_own,
  output logic             rd_own,
  output logic             full_q,
  output logic             empty_q,
  output logic             rd_en_q,
  output logic [WIDTH-1:0] rd_data
);
  localparam int AW = addr_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_acc, rd_acc;

  assign wr_acc = wr_req & wr_own & ~full_q;
  assign rd_acc = rd_req & rd_own & ~empty_q;
  assign cnt_d  = cnt_q + CW'(wr_acc) - CW'(rd_acc);

  trf_token_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wtok (
    .clk(clk), .rst(rst), .first_n(first_n), .step(wr_acc),
    .hand_in(wr_hand_in), .ptr_q(wptr), .own_q(wr_own), .hand_out(wr_hand_out));

  trf_token_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rtok (
    .clk(clk), .rst(rst), .first_n(first_n), .step(rd_acc),
    .hand_in(rd_hand_in), .ptr_q(rptr), .own_q(rd_own), .hand_out(rd_hand_out));

  trf_store #(.DEPTH(DEPTH), .AW(AW), .WIDTH(WIDTH)) u_mem (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata(wr_data),
    .re(rd_acc), .raddr(rptr), .rdata_q(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      rd_en_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      full_q  <= (cnt_d == CW'(DEPTH));
      empty_q <= (cnt_d == '0);
      rd_en_q <= rd_acc;
    end
  end

  assert_slice_hold_when_full_R2: assert property (@(posedge clk) disable iff (rst)
    (full_q && !rd_acc) |=> full_q);
  assert_slice_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/token_ring_fifo.sv
module token_ring_fifo #(
  parameter int SLICES      = 4,
  parameter int SLICE_DEPTH = 16,
  parameter int WIDTH       = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLICES-1:0] first_load_n,
  input  logic              wr_req,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_req,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [SLICES-1:0] wr_owner_o,
  output logic [SLICES-1:0] rd_owner_o
);
  logic [SLICES-1:0] wxo, rxo, wxi, rxi, sfull, sempty, sen;
  logic [WIDTH-1:0]  sdata [SLICES];

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i + SLICES - 1) % SLICES;
    assign wxi[i] = wxo[PREV];
    assign rxi[i] = rxo[PREV];

    trf_slice #(.DEPTH(SLICE_DEPTH), .WIDTH(WIDTH)) u_slice (
      .clk(clk), .rst(rst), .first_n(first_load_n[i]),
      .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
      .wr_hand_in(wxi[i]), .rd_hand_in(rxi[i]),
      .wr_hand_out(wxo[i]), .rd_hand_out(rxo[i]),
      .wr_own(wr_owner_o[i]), .rd_own(rd_owner_o[i]),
      .full_q(sfull[i]), .empty_q(sempty[i]),
      .rd_en_q(sen[i]), .rd_data(sdata[i]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < SLICES; i++) begin
      if (sen[i]) rd_data_o = rd_data_o | sdata[i];
    end
  end

  assign rd_valid_o = |sen;
  assign full_o     = |(sfull & wr_owner_o);
  assign empty_o    = |(sempty & rd_owner_o);

  assert_wr_token_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_owner_o) == 1);
  assert_rd_token_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_owner_o) == 1);
  assert_single_reader_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sen));
  assert_empty_read_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (empty_o && rd_req) |=> !rd_valid_o);
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (full_o && !rd_req) |=> full_o);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o));
endmodule

// File: tb/token_ring_fifo_bench.sv
module token_ring_fifo_bench;
  localparam int N   = 3;
  localparam int D   = 4;
  localparam int W   = 9;
  localparam int CAP = N * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] first_load_n = '1;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data_o;
  logic rd_valid_o, full_o, empty_o;
  logic [N-1:0] wr_owner_o, rd_owner_o;

  token_ring_fifo #(.SLICES(N), .SLICE_DEPTH(D), .WIDTH(W)) u_token_ring_fifo (
    .clk(clk), .rst(rst), .first_load_n(first_load_n), .wr_req(wr_req),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .full_o(full_o), .empty_o(empty_o),
    .wr_owner_o(wr_owner_o), .rd_owner_o(rd_owner_o));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  int first = 0, wtot = 0, rtot = 0;
  logic [W-1:0] dseq = 9'd1;
  logic [W-1:0] refq [$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] owner(input int ops);
    return N'(1) << ((first + ops / D) % N);
  endfunction

  task automatic reset_to(input int f);
    @(negedge clk);
    rst = 1'b1; wr_req = 0; rd_req = 0;
    first_load_n = ~(N'(1) << f);
    first = f; wtot = 0; rtot = 0;
    refq.delete();
    @(posedge clk); #1;
    chk(empty_o == 1 && full_o == 0 && rd_valid_o == 0, "R1", {full_o, empty_o}, 1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(empty_o == 1 && full_o == 0 && rd_valid_o == 0, "R1", {full_o, empty_o}, 1);
    chk(wr_owner_o == owner(0), "R7", wr_owner_o, owner(0));
    chk(rd_owner_o == owner(0), "R7", rd_owner_o, owner(0));
  endtask

  task automatic cyc(input bit w, input bit r);
    logic [W-1:0] d, exp;
    bit wacc, racc;
    d = dseq; dseq = dseq + 9'd1;
    @(negedge clk);
    wr_req = w; rd_req = r; wr_data = d;
    wacc = w && (refq.size() < CAP);
    racc = r && (refq.size() > 0);
    @(posedge clk); #1;
    if (racc) begin
      exp = refq.pop_front();
      chk(rd_valid_o == 1, "R5", rd_valid_o, 1);
      chk(rd_data_o == exp, "R4", rd_data_o, exp);
      rtot++;
    end else begin
      chk(rd_valid_o == 0, r ? "R3" : "R5", rd_valid_o, 0);
    end
    if (wacc) begin
      refq.push_back(d);
      wtot++;
    end
    if (w && r && wacc && racc) chk(1'b1, "R8", 1, 1);
    chk(full_o == (refq.size() == CAP), "R2", full_o, refq.size() == CAP);
    chk(empty_o == (refq.size() == 0), "R9", empty_o, refq.size() == 0);
    chk(wr_owner_o == owner(wtot), "R6", wr_owner_o, owner(wtot));
    chk(rd_owner_o == owner(rtot), "R6", rd_owner_o, owner(rtot));
  endtask

  initial begin
    for (int f = 0; f < N; f++) begin
      reset_to(f);
      cyc(0, 1); cyc(0, 1);                       // R3 reads of empty
      for (int i = 0; i < CAP + 3; i++) cyc(1, 0); // R2 overfill
      cyc(1, 1);                                  // full: write dropped, read taken
      cyc(1, 0);
      for (int i = 0; i < D + 1; i++) cyc(0, 1);  // tokens one lap apart
      for (int i = 0; i < 60; i++) cyc((i % 3) != 0, (i % 2) == 0);
      for (int i = 0; i < 40; i++) cyc(1, 1);     // R8 concurrent
      for (int i = 0; i < 30; i++) cyc((i % 5) < 3, (i % 4) != 0);
      for (int i = 0; i < CAP + 2; i++) cyc(0, 1); // drain past empty
      for (int i = 0; i < 7; i++) cyc(1, 0);
      for (int i = 0; i < 25; i++) cyc((i % 2) == 0, 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule